// File: doc/BRIEF.md
# Posit Operand Pair Decoder

This block is the front stage of a posit dot-product datapath. On every clock it takes two vectors of posit words, `vec_a` and `vec_b`, each with `LANES` elements, together with one accumulator posit. Every word is decoded at the same time by its own decoder. A decoder produces the sign, a signed scale exponent and a left-aligned mantissa that carries the hidden one. Each lane then merges its two operands into the product sign and product exponent that a multiplier and aligner further down need. The mantissas go on unchanged so that the multiplier can consume them.

The word size `NW` and the exponent field size `ES` are parameters, and any pair with `NW >= ES + 2` is accepted. The regime run is measured with a leading-zero count on the magnitude body, inverted when needed. A logarithmic barrel shift then removes the run and its terminating bit, and this leaves the exponent and fraction fields at the top of the word. All results are captured in a single output register, so the latency is one cycle and one new operand set can be accepted on every cycle.

Top module: `posit_pair_decode`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: For a word that is neither zero nor NaR, the decoded mantissa is `NW-ES` bits wide. Its MSB is the hidden one, and the fraction bits follow it, left-aligned, with zeros below them.
- R3: The scale exponent equals regime × 2^ES plus the exponent field. The regime is −k for a leading run of k zeros and k−1 for a leading run of k ones. The run is measured on the `NW-1` bits below the sign.
- R4: A word whose MSB is 1 (other than NaR) is decoded from its two's complement. Its sign is reported as 1.
- R5: Exponent field bits that would lie past the LSB of the word are taken as 0.
- R6: The all-zero word is zero. Its sign, scale and mantissa decode to 0.
- R7: The word with only the MSB set is NaR. Its sign, scale and mantissa decode to 0.
- R8: When neither operand of a lane is zero or NaR, `prod_sign` is the XOR of the two operand signs.
- R9: When neither operand of a lane is zero or NaR, `prod_exp` is the signed sum of the two scale exponents.
- R10: `prod_nar` is set when either operand is NaR. `prod_zero` is set when either operand is zero and neither is NaR. When either flag is set, `prod_sign` and `prod_exp` are 0, and `man_a`/`man_b` still carry each operand's own decode.
- R11: The accumulator word is decoded by the same rules onto `acc_sign`, `acc_scale`, `acc_man`, `acc_zero` and `acc_nar`.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge, for all lanes and the accumulator at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_a | input | LANES×NW | First operand vector |
| vec_b | input | LANES×NW | Second operand vector |
| acc_in | input | NW | Accumulator posit |
| prod_sign | output | LANES | Product sign per lane |
| prod_exp | output | LANES×PW | Signed product exponent per lane, PW = SW+1 |
| man_a | output | LANES×MW | Mantissa of each `vec_a` element, MW = NW−ES |
| man_b | output | LANES×MW | Mantissa of each `vec_b` element |
| prod_zero | output | LANES | Product is zero |
| prod_nar | output | LANES | Product is NaR |
| acc_sign | output | 1 | Accumulator sign |
| acc_scale | output | SW | Signed accumulator scale, SW = clog2(NW)+1+ES |
| acc_man | output | MW | Accumulator mantissa |
| acc_zero | output | 1 | Accumulator is zero |
| acc_nar | output | 1 | Accumulator is NaR |

## Verification
Some properties are checked on every cycle against the inputs of the cycle before. These are the product flags and the accumulator flags, and they are compared with raw comparisons on the input words. The checks also confirm that a special lane reports a quiet sign and exponent, that normal lanes carry the hidden one and the XOR sign, and that the outputs stay at zero during reset. The numeric results cannot be checked that way. These are the regime run length, the scale arithmetic, the fraction alignment, two's complement handling and cut-off exponent bits. Only the bench shows them, by comparing each lane with a bit-walking reference decoder, using the extreme regime words, negative words and random vectors.

// File: rtl/posit_pkg.sv
package posit_pkg;

    // Classification of one decoded word
    typedef enum logic [1:0] {
        WORD_NUM  = 2'd0,
        WORD_ZERO = 2'd1,
        WORD_NAR  = 2'd2
    } word_kind_e;

endpackage

// File: rtl/posit_lead_count.sv
// Counts leading zeros of a W-bit vector; all-zero gives W.
module posit_lead_count #(
    parameter int W  = 7,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/posit_left_shift.sv
// Logarithmic left shifter, zeros fill from the right.
module posit_left_shift #(
    parameter int W  = 7,
    parameter int SB = 3
) (
    input  logic [W-1:0]  din,
    input  logic [SB-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SB+1];

    assign stage[0] = din;

    for (genvar s = 0; s < SB; s++) begin : g_stage
        localparam int STEP = 1 << s;
        if (STEP >= W) begin : g_clear
            assign stage[s+1] = amt[s] ? '0 : stage[s];
        end else begin : g_move
            assign stage[s+1] = amt[s] ? {stage[s][W-1-STEP:0], {STEP{1'b0}}} : stage[s];
        end
    end

    assign dout = stage[SB];
endmodule

// File: rtl/posit_word_decode.sv
// Decodes one posit word into sign, scale exponent and mantissa.
module posit_word_decode
    import posit_pkg::*;
#(
    parameter int NW = 8,
    parameter int ES = 1,
    localparam int BW  = NW - 1,
    localparam int KW  = $clog2(NW),
    localparam int RW  = KW + 1,
    localparam int SW  = RW + ES,
    localparam int MW  = NW - ES,
    localparam int SB  = $clog2(NW + 1),
    localparam int EXW = (ES > 0) ? ES : 1
) (
    input  logic [NW-1:0] word,
    output logic          sign,
    output logic [SW-1:0] scale,
    output logic [MW-1:0] mant,
    output word_kind_e    kind
);
    localparam logic [RW-1:0] ONE_R = RW'(1);

    logic [NW-1:0]  mag;
    logic [BW-1:0]  body;
    logic           run_bit;
    logic [BW-1:0]  probe;
    logic [KW-1:0]  run_len;
    logic [SB-1:0]  strip;
    logic [BW-1:0]  rest;
    logic [RW-1:0]  run_ext;
    logic [RW-1:0]  regime;
    logic [EXW-1:0] exp_f;
    logic           is_zero;
    logic           is_nar;

    assign is_zero = (word == '0);
    assign is_nar  = (word == {1'b1, {BW{1'b0}}});

    // magnitude from two's complement when negative
    assign mag     = word[NW-1] ? (~word + NW'(1)) : word;
    assign body    = mag[BW-1:0];
    assign run_bit = body[BW-1];
    assign probe   = run_bit ? ~body : body;

    posit_lead_count #(.W(BW), .CW(KW)) u_count (
        .vec   (probe),
        .count (run_len)
    );

    // drop the run and its terminator
    assign strip = SB'(run_len) + SB'(1);

    posit_left_shift #(.W(BW), .SB(SB)) u_shift (
        .din  (body),
        .amt  (strip),
        .dout (rest)
    );

    assign run_ext = {1'b0, run_len};
    assign regime  = run_bit ? (run_ext - ONE_R) : (~run_ext + ONE_R);

    if (ES > 0) begin : g_exp
        assign exp_f = rest[BW-1 -: ES];
    end else begin : g_noexp
        assign exp_f = 1'b0;
    end

    always_comb begin
        if (is_zero) begin
            kind  = WORD_ZERO;
            sign  = 1'b0;
            scale = '0;
            mant  = '0;
        end else if (is_nar) begin
            kind  = WORD_NAR;
            sign  = 1'b0;
            scale = '0;
            mant  = '0;
        end else begin
            kind  = WORD_NUM;
            sign  = word[NW-1];
            scale = (SW'($signed(regime)) << ES) | SW'(exp_f);
            mant  = {1'b1, rest[BW-1-ES:0]};
        end
    end
endmodule

// File: rtl/posit_pair_decode.sv
// Lane-parallel operand decoder with product sign/exponent and one output register.
module posit_pair_decode
    import posit_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NW    = 8,
    parameter int ES    = 1,
    localparam int KW   = $clog2(NW),
    localparam int SW   = KW + 1 + ES,
    localparam int PW   = SW + 1,
    localparam int MW   = NW - ES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0][NW-1:0]   vec_a,
    input  logic [LANES-1:0][NW-1:0]   vec_b,
    input  logic [NW-1:0]              acc_in,
    output logic [LANES-1:0]           prod_sign,
    output logic [LANES-1:0][PW-1:0]   prod_exp,
    output logic [LANES-1:0][MW-1:0]   man_a,
    output logic [LANES-1:0][MW-1:0]   man_b,
    output logic [LANES-1:0]           prod_zero,
    output logic [LANES-1:0]           prod_nar,
    output logic                       acc_sign,
    output logic [SW-1:0]              acc_scale,
    output logic [MW-1:0]              acc_man,
    output logic                       acc_zero,
    output logic                       acc_nar
);
    logic [LANES-1:0]         ps_d, pz_d, pn_d;
    logic [LANES-1:0][PW-1:0] pe_d;
    logic [LANES-1:0][MW-1:0] ma_d, mb_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic          sa, sb;
        logic [SW-1:0] ea, eb;
        word_kind_e    ka, kb;

        posit_word_decode #(.NW(NW), .ES(ES)) u_dec_a (
            .word (vec_a[i]), .sign (sa), .scale (ea), .mant (ma_d[i]), .kind (ka)
        );
        posit_word_decode #(.NW(NW), .ES(ES)) u_dec_b (
            .word (vec_b[i]), .sign (sb), .scale (eb), .mant (mb_d[i]), .kind (kb)
        );

        always_comb begin
            pn_d[i] = (ka == WORD_NAR) || (kb == WORD_NAR);
            pz_d[i] = !pn_d[i] && ((ka == WORD_ZERO) || (kb == WORD_ZERO));
            if (pn_d[i] || pz_d[i]) begin
                ps_d[i] = 1'b0;
                pe_d[i] = '0;
            end else begin
                ps_d[i] = sa ^ sb;
                pe_d[i] = PW'($signed(ea)) + PW'($signed(eb));
            end
        end
    end

    logic          as_d;
    logic [SW-1:0] ae_d;
    logic [MW-1:0] am_d;
    word_kind_e    ak_d;

    posit_word_decode #(.NW(NW), .ES(ES)) u_dec_acc (
        .word (acc_in), .sign (as_d), .scale (ae_d), .mant (am_d), .kind (ak_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_sign <= '0;
            prod_exp  <= '0;
            man_a     <= '0;
            man_b     <= '0;
            prod_zero <= '0;
            prod_nar  <= '0;
            acc_sign  <= 1'b0;
            acc_scale <= '0;
            acc_man   <= '0;
            acc_zero  <= 1'b0;
            acc_nar   <= 1'b0;
        end else begin
            prod_sign <= ps_d;
            prod_exp  <= pe_d;
            man_a     <= ma_d;
            man_b     <= mb_d;
            prod_zero <= pz_d;
            prod_nar  <= pn_d;
            acc_sign  <= as_d;
            acc_scale <= ae_d;
            acc_man   <= am_d;
            acc_zero  <= (ak_d == WORD_ZERO);
            acc_nar   <= (ak_d == WORD_NAR);
        end
    end
endmodule

// File: rtl/posit_pair_decode_chk.sv
module posit_pair_decode_chk #(
    parameter int LANES = 4,
    parameter int NW    = 8,
    parameter int ES    = 1,
    localparam int KW   = $clog2(NW),
    localparam int SW   = KW + 1 + ES,
    localparam int PW   = SW + 1,
    localparam int MW   = NW - ES
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [LANES-1:0][NW-1:0] vec_a,
    input logic [LANES-1:0][NW-1:0] vec_b,
    input logic [NW-1:0]            acc_in,
    input logic [LANES-1:0]         prod_sign,
    input logic [LANES-1:0][PW-1:0] prod_exp,
    input logic [LANES-1:0][MW-1:0] man_a,
    input logic [LANES-1:0][MW-1:0] man_b,
    input logic [LANES-1:0]         prod_zero,
    input logic [LANES-1:0]         prod_nar,
    input logic                     acc_sign,
    input logic [SW-1:0]            acc_scale,
    input logic [MW-1:0]            acc_man,
    input logic                     acc_zero,
    input logic                     acc_nar
);
    localparam logic [NW-1:0] NAR_W = {1'b1, {(NW-1){1'b0}}};

    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert ((prod_sign == '0) && (prod_exp == '0) && (man_a == '0)
                && (man_b == '0) && (prod_zero == '0) && (prod_nar == '0) && !acc_sign
                && (acc_scale == '0) && (acc_man == '0) && !acc_zero && !acc_nar);
        end
    end

    // R11
    acc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (acc_zero == ($past(acc_in) == '0)) && (acc_nar == ($past(acc_in) == NAR_W)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R10
        nar_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            prod_nar[i] == (($past(vec_a[i]) == NAR_W) || ($past(vec_b[i]) == NAR_W)));

        // R10
        zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            prod_zero[i] == (!prod_nar[i] &&
                (($past(vec_a[i]) == '0) || ($past(vec_b[i]) == '0))));

        // R10
        special_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            (prod_zero[i] || prod_nar[i]) |-> (!prod_sign[i] && (prod_exp[i] == '0)));

        // R2
        hidden_one_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            !(prod_zero[i] || prod_nar[i]) |-> (man_a[i][MW-1] && man_b[i][MW-1]));

        // R8
        sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
            !(prod_zero[i] || prod_nar[i]) |->
                (prod_sign[i] == ($past(vec_a[i][NW-1]) ^ $past(vec_b[i][NW-1]))));
    end
endmodule

bind posit_pair_decode posit_pair_decode_chk #(.LANES(LANES), .NW(NW), .ES(ES)) u_chk (.*);

// File: tb/posit_pair_decode_test.sv
module posit_pair_decode_test;
    localparam int LANES = 4;
    localparam int NW    = 8;
    localparam int ES    = 1;
    localparam int KW    = $clog2(NW);
    localparam int SW    = KW + 1 + ES;
    localparam int PW    = SW + 1;
    localparam int MW    = NW - ES;

    typedef struct {
        int sgn;
        int scl;
        int man;
        int zer;
        int nar;
    } ref_t;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b1;
    logic [LANES-1:0][NW-1:0] vec_a = '0;
    logic [LANES-1:0][NW-1:0] vec_b = '0;
    logic [NW-1:0]            acc_in = '0;
    logic [LANES-1:0]         prod_sign, prod_zero, prod_nar;
    logic [LANES-1:0][PW-1:0] prod_exp;
    logic [LANES-1:0][MW-1:0] man_a, man_b;
    logic                     acc_sign, acc_zero, acc_nar;
    logic [SW-1:0]            acc_scale;
    logic [MW-1:0]            acc_man;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    posit_pair_decode #(.LANES(LANES), .NW(NW), .ES(ES)) uut (
        .clk, .rst_n, .vec_a, .vec_b, .acc_in,
        .prod_sign, .prod_exp, .man_a, .man_b, .prod_zero, .prod_nar,
        .acc_sign, .acc_scale, .acc_man, .acc_zero, .acc_nar
    );

    // bit-walking reference decoder
    function automatic ref_t ref_dec(input logic [NW-1:0] w);
        ref_t r;
        logic [NW-1:0] m;
        int pos, k, e, fp;
        logic rb;
        r = '{0, 0, 0, 0, 0};
        if (w == '0) begin r.zer = 1; return r; end
        if (w == {1'b1, {(NW-1){1'b0}}}) begin r.nar = 1; return r; end
        r.sgn = w[NW-1];
        m = w[NW-1] ? NW'(-int'(w)) : w;
        rb = m[NW-2];
        k = 0;
        pos = NW - 2;
        while (pos >= 0 && m[pos] == rb) begin k++; pos--; end
        pos--;
        e = 0;
        for (int j = 0; j < ES; j++) begin
            e = e * 2 + ((pos >= 0) ? int'(m[pos]) : 0);
            pos--;
        end
        r.scl = (rb ? (k - 1) : -k) * (1 << ES) + e;
        r.man = 1 << (MW - 1);
        fp = MW - 2;
        while (pos >= 0) begin
            r.man = r.man | (int'(m[pos]) << fp);
            fp--;
            pos--;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag);
        ref_t ra, rb, rc;
        int   spec;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) begin
            ra = ref_dec(vec_a[i]);
            rb = ref_dec(vec_b[i]);
            spec = ra.zer | rb.zer | ra.nar | rb.nar;
            chk($sformatf("%s R8 lane%0d sign", tag, i), int'(prod_sign[i]),
                spec ? 0 : (ra.sgn ^ rb.sgn));
            chk($sformatf("%s R9 R3 lane%0d exp", tag, i), int'($signed(prod_exp[i])),
                spec ? 0 : (ra.scl + rb.scl));
            chk($sformatf("%s R2 lane%0d man_a", tag, i), int'(man_a[i]), ra.man);
            chk($sformatf("%s R2 lane%0d man_b", tag, i), int'(man_b[i]), rb.man);
            chk($sformatf("%s R10 lane%0d nar", tag, i), int'(prod_nar[i]), ra.nar | rb.nar);
            chk($sformatf("%s R10 lane%0d zero", tag, i), int'(prod_zero[i]),
                (ra.nar | rb.nar) ? 0 : (ra.zer | rb.zer));
        end
        rc = ref_dec(acc_in);
        chk($sformatf("%s R11 acc sign", tag), int'(acc_sign), rc.sgn);
        chk($sformatf("%s R11 acc scale", tag), int'($signed(acc_scale)), rc.scl);
        chk($sformatf("%s R11 acc man", tag), int'(acc_man), rc.man);
        chk($sformatf("%s R11 acc zero", tag), int'(acc_zero), rc.zer);
        chk($sformatf("%s R11 acc nar", tag), int'(acc_nar), rc.nar);
    endtask

    task automatic set_lanes(input logic [NW-1:0] a0, a1, a2, a3,
                             input logic [NW-1:0] b0, b1, b2, b3,
                             input logic [NW-1:0] c);
        vec_a  = {a3, a2, a1, a0};
        vec_b  = {b3, b2, b1, b0};
        acc_in = c;
    endtask

    initial begin
        int seed;
        ref_t t;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        set_lanes(8'h40, 8'h7F, 8'h01, 8'hC0, 8'h40, 8'h7F, 8'h01, 8'hC0, 8'h7F);
        #2 rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: outputs held at zero while reset is low
        chk("R1 prod_exp", int'(prod_exp), 0);
        chk("R1 man_a", int'(man_a), 0);
        chk("R1 flags", int'({prod_zero, prod_nar, prod_sign}), 0);
        chk("R1 acc", int'({acc_sign, acc_scale, acc_man, acc_zero, acc_nar}), 0);
        rst_n = 1'b1;

        // R3: unity, max and min regime runs; direct reference spot values
        t = ref_dec(8'h7F);
        chk("R3 ref maxpos scale", t.scl, 12);
        t = ref_dec(8'h01);
        chk("R3 ref minpos scale", t.scl, -12);
        apply("R3");
        // R4: negative words through two's complement
        set_lanes(8'hFF, 8'h81, 8'hC0, 8'hB3, 8'h40, 8'h81, 8'h3A, 8'hE5, 8'hA7);
        apply("R4");
        // R5: regime ends at LSB, exponent bit cut off
        set_lanes(8'h7E, 8'h02, 8'h7D, 8'h03, 8'h7E, 8'h40, 8'h06, 8'hFE, 8'h7E);
        apply("R5");
        // R6: zero operands in various lanes
        set_lanes(8'h00, 8'h55, 8'h00, 8'h80, 8'h91, 8'h00, 8'h00, 8'h00, 8'h00);
        apply("R6");
        // R7: NaR operands, including NaR with zero
        set_lanes(8'h80, 8'h80, 8'h00, 8'h12, 8'h33, 8'h80, 8'h80, 8'h80, 8'h80);
        apply("R7");
        // R12: random vectors, a new set every cycle
        for (int v = 0; v < 60; v++) begin
            for (int i = 0; i < LANES; i++) begin
                vec_a[i] = NW'($urandom);
                vec_b[i] = NW'($urandom);
            end
            acc_in = NW'($urandom);
            apply("R12");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule